// File: doc/BRIEF.md
# Job Ring Occupancy Tracker

This block keeps the bookkeeping for one pair of circular job rings shared between software and a processing engine. On the request ring, software posts work and the engine takes it. On the completion ring, the engine writes results and software retires them. Software never moves a pointer. It reports how many jobs it added or removed, and the block keeps the engine-side indices, the pending and free counts of the request ring, and the filled count of the completion ring.

Software reaches the block through a single-cycle register write port. A 3-bit select picks the target: request-ring size (0), completion-ring size (1), jobs-added count (2), jobs-removed count (3), configuration (4), command (5) and status clear (6). The engine gives a one-cycle strobe for each request it takes and for each completion it writes. A count that would overflow a ring is refused, and the block records it as a typed error. A two-step halt sequence empties both rings. A level interrupt output follows the status bits and the mask.

Top module: `jring_occ_mgr`

## Requirements
- R1: From reset every output is zero. A size write takes `wr_data_i[9:0]` as the new ring size and clears that ring's count and index on the same edge; an engine strobe for that ring in that cycle is dropped.
- R2: An accepted jobs-added write raises the pending count by `wr_data_i[9:0]`, and `in_avail_o` always equals the request-ring size minus the pending count.
- R3: A jobs-added write that would take the pending count above the size is refused with the count unchanged. It sets status bit 1 and loads error type 9 into status bits 11:8.
- R4: A take strobe with pending jobs lowers the pending count by one and advances `in_rd_idx_o`, wrapping to 0 at the size. With nothing pending the strobe has no effect. An add and a take in the same cycle both apply, and the overflow test uses the count held before that edge.
- R5: A completion strobe with the completion ring not full raises `out_full_o` by one and advances `out_wr_idx_o`, wrapping to 0 at the size. When the ring is full the strobe has no effect.
- R6: A jobs-removed write lowers `out_full_o` by `wr_data_i[9:0]`. A count above `out_full_o` is refused with the count unchanged, sets status bit 1 and loads error type 8.
- R7: Status bit 0 is set on each accepted completion. A status-clear write with data bit 0 or bit 1 at 1 clears that bit, and clearing bit 1 also zeroes the type field. A bit being set in the same cycle takes precedence over the clear.
- R8: `irq_o` is high when status bit 0 or bit 1 is set and configuration bit 0 (mask) is 0. With the mask at 1 the status bits still update but `irq_o` stays low.
- R9: With configuration bit 1 (coalescing) at 1, status bit 0 is set only by a completion that brings `out_full_o` to at least the threshold in configuration bits 15:3. A threshold of 0 counts as 1.
- R10: With configuration bit 2 (stop on error) at 1 and status bit 1 set, both engine strobes are ignored. They take effect again once the error is cleared.
- R11: A command write with bit 0 at 1 from idle sets status bits 3:2 to 01 (halt in progress) for one cycle. The following edge clears both counts and both indices, keeps the sizes, and sets bits 3:2 to 10 (halt done). A further reset command returns bits 3:2 to 00. While bits 3:2 are nonzero, engine strobes and add or remove writes are ignored.
- R12: A reset command written while bits 3:2 read 01 sets status bit 1 with error type 7. The halt still completes on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select |
| wr_data_i | input | 16 | Write data |
| eng_take_i | input | 1 | Engine took one request |
| eng_done_i | input | 1 | Engine wrote one completion |
| in_size_o | output | 10 | Request-ring size |
| in_avail_o | output | 10 | Free request slots |
| in_pend_o | output | 10 | Requests not yet taken |
| in_rd_idx_o | output | 10 | Request-ring read index |
| out_size_o | output | 10 | Completion-ring size |
| out_full_o | output | 10 | Filled completion slots |
| out_wr_idx_o | output | 10 | Completion-ring write index |
| irq_status_o | output | 12 | Status: done bit 0, error bit 1, halt bits 3:2, type bits 11:8 |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench works the ring boundaries: an add that exactly fills the request ring, an add one past it, a remove one above the filled count, and index wraps on both rings. A design that compared with the wrong bound would either refuse the exact fill or let the excess add through. A design with an off-by-one wrap would show an index equal to the size. Take strobes on an empty ring and completions on a full ring must change nothing, or the counts drift. The bench also checks a take in the same cycle as an add, a completion in the same cycle as a size write, the exact completion that crosses the coalescing threshold, strobes blocked by stop-on-error, and a reset command issued during the halt-in-progress cycle. A design that mishandled any of these would show a wrong count, a late or early done bit, or a missing type 7 error.

// File: rtl/jring_pkg.sv
package jring_pkg;
  typedef enum logic [2:0] {
    SEL_IN_SIZE  = 3'd0,
    SEL_OUT_SIZE = 3'd1,
    SEL_ADD      = 3'd2,
    SEL_REMOVE   = 3'd3,
    SEL_CFG      = 3'd4,
    SEL_CMD      = 3'd5,
    SEL_STAT     = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    HALT_IDLE = 2'b00,
    HALT_PROG = 2'b01,
    HALT_DONE = 2'b10
  } halt_e;

  localparam int ETYPE_W = 4;
  localparam logic [ETYPE_W-1:0] ERR_RESET  = 4'd7;
  localparam logic [ETYPE_W-1:0] ERR_REMOVE = 4'd8;
  localparam logic [ETYPE_W-1:0] ERR_ADD    = 4'd9;
  localparam int STAT_W = 12;
endpackage

// File: rtl/jring_slot_ctr.sv
module jring_slot_ctr #(
  parameter int SIZE_W   = 10,
  parameter bit BULK_ADD = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              size_we_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              bulk_vld_i,
  input  logic [SIZE_W-1:0] bulk_n_i,
  input  logic              step_req_i,
  input  logic              flush_i,
  output logic [SIZE_W-1:0] size_o,
  output logic [SIZE_W-1:0] cnt_o,
  output logic [SIZE_W-1:0] idx_o,
  output logic              step_ok_o,
  output logic              bulk_err_o
);
  localparam logic [SIZE_W:0] ONE = (SIZE_W+1)'(1);

  logic [SIZE_W-1:0] size_q, cnt_q, idx_q, idx_nxt;
  logic [SIZE_W:0]   acc, idx_inc;
  logic              bulk_bad, room, step_ok;

  generate
    if (BULK_ADD) begin : g_add
      // request ring: software adds, engine takes
      always_comb begin
        bulk_bad = ({1'b0, cnt_q} + {1'b0, bulk_n_i}) > {1'b0, size_q};
        room     = (cnt_q != '0);
      end
    end else begin : g_sub
      // completion ring: engine fills, software removes
      always_comb begin
        bulk_bad = bulk_n_i > cnt_q;
        room     = cnt_q < size_q;
      end
    end
  endgenerate

  assign step_ok = step_req_i & room & ~size_we_i & ~flush_i;

  always_comb begin
    acc = {1'b0, cnt_q};
    if (bulk_vld_i && !bulk_bad) acc = BULK_ADD ? acc + {1'b0, bulk_n_i} : acc - {1'b0, bulk_n_i};
    if (step_ok) acc = BULK_ADD ? acc - ONE : acc + ONE;
    idx_inc = {1'b0, idx_q} + ONE;
    idx_nxt = (idx_inc >= {1'b0, size_q}) ? '0 : idx_inc[SIZE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      if (size_we_i) size_q <= size_i;
      if (flush_i || size_we_i) begin
        cnt_q <= '0;
        idx_q <= '0;
      end else begin
        cnt_q <= acc[SIZE_W-1:0];
        if (step_ok) idx_q <= idx_nxt;
      end
    end
  end

  assign size_o     = size_q;
  assign cnt_o      = cnt_q;
  assign idx_o      = idx_q;
  assign step_ok_o  = step_ok;
  assign bulk_err_o = bulk_vld_i & bulk_bad;
endmodule

// File: rtl/jring_ctrl.sv
module jring_ctrl
  import jring_pkg::*;
#(
  parameter int SIZE_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eng_take_i,
  input  logic              eng_done_i,
  input  logic              add_err_i,
  input  logic              rem_err_i,
  input  logic              done_ok_i,
  input  logic [SIZE_W-1:0] out_cnt_i,
  output logic              in_size_we_o,
  output logic              out_size_we_o,
  output logic              add_vld_o,
  output logic              rem_vld_o,
  output logic              take_req_o,
  output logic              done_req_o,
  output logic              flush_o,
  output logic              cfg_mask_o,
  output logic [STAT_W-1:0] irq_status_o,
  output logic              irq_o
);
  localparam int THR_W = DATA_W - 3;
  localparam int CMP_W = ((SIZE_W > THR_W) ? SIZE_W : THR_W) + 1;

  halt_e              halt_q, halt_d;
  logic               mask_q, coal_q, soe_q;
  logic [THR_W-1:0]   thr_q;
  logic               done_q, err_q;
  logic [ETYPE_W-1:0] type_q, err_code;
  logic               halted, blocked, cmd_rst, rst_err, new_err, done_set;
  logic [1:0]         clr;
  logic [CMP_W-1:0]   lvl, thr_eff;

  function automatic logic sel_hit(input logic [2:0] s, input reg_sel_e r);
    return s == 3'(r);
  endfunction

  assign halted  = (halt_q != HALT_IDLE);
  assign blocked = soe_q & err_q;
  assign cmd_rst = wr_en_i & sel_hit(wr_sel_i, SEL_CMD) & wr_data_i[0];
  assign rst_err = cmd_rst & (halt_q == HALT_PROG);
  assign flush_o = (halt_q == HALT_PROG);

  assign in_size_we_o  = wr_en_i & sel_hit(wr_sel_i, SEL_IN_SIZE);
  assign out_size_we_o = wr_en_i & sel_hit(wr_sel_i, SEL_OUT_SIZE);
  assign add_vld_o     = wr_en_i & sel_hit(wr_sel_i, SEL_ADD) & ~halted;
  assign rem_vld_o     = wr_en_i & sel_hit(wr_sel_i, SEL_REMOVE) & ~halted;
  assign take_req_o    = eng_take_i & ~halted & ~blocked;
  assign done_req_o    = eng_done_i & ~halted & ~blocked;

  always_comb begin
    halt_d = halt_q;
    unique case (halt_q)
      HALT_IDLE: if (cmd_rst) halt_d = HALT_PROG;
      HALT_PROG: halt_d = HALT_DONE;
      HALT_DONE: if (cmd_rst) halt_d = HALT_IDLE;
      default:   halt_d = HALT_IDLE;
    endcase
  end

  always_comb begin
    new_err  = add_err_i | rem_err_i | rst_err;
    err_code = add_err_i ? ERR_ADD : (rem_err_i ? ERR_REMOVE : ERR_RESET);
    lvl      = CMP_W'(out_cnt_i) + CMP_W'(1);
    thr_eff  = (thr_q == '0) ? CMP_W'(1) : CMP_W'(thr_q);
    done_set = done_ok_i & (~coal_q | (lvl >= thr_eff));
    clr      = (wr_en_i && sel_hit(wr_sel_i, SEL_STAT)) ? wr_data_i[1:0] : 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= HALT_IDLE;
      mask_q <= 1'b0;
      coal_q <= 1'b0;
      soe_q  <= 1'b0;
      thr_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      type_q <= '0;
    end else begin
      halt_q <= halt_d;
      if (wr_en_i && sel_hit(wr_sel_i, SEL_CFG)) begin
        mask_q <= wr_data_i[0];
        coal_q <= wr_data_i[1];
        soe_q  <= wr_data_i[2];
        thr_q  <= wr_data_i[DATA_W-1:3];
      end
      done_q <= done_set | (done_q & ~clr[0]);
      err_q  <= new_err | (err_q & ~clr[1]);
      if (new_err)     type_q <= err_code;
      else if (clr[1]) type_q <= '0;
    end
  end

  assign cfg_mask_o   = mask_q;
  assign irq_status_o = {type_q, 4'b0000, 2'(halt_q), err_q, done_q};
  assign irq_o        = (done_q | err_q) & ~mask_q;
endmodule

// File: rtl/jring_occ_mgr.sv
module jring_occ_mgr
  import jring_pkg::*;
#(
  parameter int SIZE_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              eng_take_i,
  input  logic              eng_done_i,
  output logic [SIZE_W-1:0] in_size_o,
  output logic [SIZE_W-1:0] in_avail_o,
  output logic [SIZE_W-1:0] in_pend_o,
  output logic [SIZE_W-1:0] in_rd_idx_o,
  output logic [SIZE_W-1:0] out_size_o,
  output logic [SIZE_W-1:0] out_full_o,
  output logic [SIZE_W-1:0] out_wr_idx_o,
  output logic [STAT_W-1:0] irq_status_o,
  output logic              irq_o
);
  logic in_size_we, out_size_we, add_vld, rem_vld, take_req, done_req, flush;
  logic in_bulk_err, out_bulk_err, take_ok, done_ok, cfg_mask;
  logic [SIZE_W-1:0] in_cnt, out_cnt;

  jring_ctrl #(.SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .eng_take_i, .eng_done_i,
    .add_err_i(in_bulk_err), .rem_err_i(out_bulk_err), .done_ok_i(done_ok),
    .out_cnt_i(out_cnt), .in_size_we_o(in_size_we), .out_size_we_o(out_size_we),
    .add_vld_o(add_vld), .rem_vld_o(rem_vld), .take_req_o(take_req),
    .done_req_o(done_req), .flush_o(flush), .cfg_mask_o(cfg_mask),
    .irq_status_o, .irq_o
  );

  jring_slot_ctr #(.SIZE_W(SIZE_W), .BULK_ADD(1'b1)) u_in_ring (
    .clk_i, .rst_ni, .size_we_i(in_size_we), .size_i(wr_data_i[SIZE_W-1:0]),
    .bulk_vld_i(add_vld), .bulk_n_i(wr_data_i[SIZE_W-1:0]), .step_req_i(take_req),
    .flush_i(flush), .size_o(in_size_o), .cnt_o(in_cnt), .idx_o(in_rd_idx_o),
    .step_ok_o(take_ok), .bulk_err_o(in_bulk_err)
  );

  jring_slot_ctr #(.SIZE_W(SIZE_W), .BULK_ADD(1'b0)) u_out_ring (
    .clk_i, .rst_ni, .size_we_i(out_size_we), .size_i(wr_data_i[SIZE_W-1:0]),
    .bulk_vld_i(rem_vld), .bulk_n_i(wr_data_i[SIZE_W-1:0]), .step_req_i(done_req),
    .flush_i(flush), .size_o(out_size_o), .cnt_o(out_cnt), .idx_o(out_wr_idx_o),
    .step_ok_o(done_ok), .bulk_err_o(out_bulk_err)
  );

  logic take_seen;
  assign take_seen  = take_ok;
  assign in_pend_o  = in_cnt;
  assign in_avail_o = in_size_o - in_cnt;
  assign out_full_o = out_cnt;
endmodule

module jring_occ_chk #(
  parameter int SIZE_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SIZE_W-1:0] in_size_o,
  input logic [SIZE_W-1:0] in_avail_o,
  input logic [SIZE_W-1:0] in_rd_idx_o,
  input logic [SIZE_W-1:0] out_size_o,
  input logic [SIZE_W-1:0] out_full_o,
  input logic [SIZE_W-1:0] out_wr_idx_o,
  input logic [11:0]       irq_status_o,
  input logic              irq_o,
  input logic              cfg_mask_i,
  input logic              add_err_i
);
  assert_avail_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_avail_o <= in_size_o);
  assert_add_ovf_type_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_err_i |=> (irq_status_o[1] && irq_status_o[11:8] == 4'd9));
  assert_rd_idx_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_size_o != '0) |-> (in_rd_idx_o < in_size_o));
  assert_wr_idx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_size_o != '0) |-> (out_wr_idx_o < out_size_o));
  assert_full_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_full_o <= out_size_o);
  assert_mask_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_mask_i |-> !irq_o);
  assert_halt_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_status_o[3:2] == 2'b01) |=>
      (irq_status_o[3:2] == 2'b10 && out_full_o == '0 && in_avail_o == in_size_o));
  assert_halt_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_status_o[3:2]));
endmodule

bind jring_occ_mgr jring_occ_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_size_o(in_size_o), .in_avail_o(in_avail_o),
  .in_rd_idx_o(in_rd_idx_o), .out_size_o(out_size_o), .out_full_o(out_full_o),
  .out_wr_idx_o(out_wr_idx_o), .irq_status_o(irq_status_o), .irq_o(irq_o),
  .cfg_mask_i(cfg_mask), .add_err_i(in_bulk_err)
);

// File: tb/jring_occ_mgr_tb.sv
module jring_occ_mgr_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, take = 1'b0, done = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [9:0] in_size, in_avail, in_pend, in_rd_idx, out_size, out_full, out_wr_idx;
  logic [11:0] irq_status;
  logic irq;

  always #4 clk = ~clk;

  jring_occ_mgr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .eng_take_i(take), .eng_done_i(done), .in_size_o(in_size), .in_avail_o(in_avail),
    .in_pend_o(in_pend), .in_rd_idx_o(in_rd_idx), .out_size_o(out_size),
    .out_full_o(out_full), .out_wr_idx_o(out_wr_idx), .irq_status_o(irq_status), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference model state
  int m_isz = 0, m_icnt = 0, m_ridx = 0, m_osz = 0, m_ocnt = 0, m_widx = 0;
  int m_halt = 0, m_type = 0, m_thr = 0;
  bit m_done = 0, m_err = 0, m_mask = 0, m_coal = 0, m_soe = 0;

  task automatic chk(string name, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h", cur_req, name, got, exp);
    end
  endtask

  task automatic compare();
    chk("in_size", in_size, m_isz);
    chk("in_avail", in_avail, m_isz - m_icnt);
    chk("in_pend", in_pend, m_icnt);
    chk("in_rd_idx", in_rd_idx, m_ridx);
    chk("out_size", out_size, m_osz);
    chk("out_full", out_full, m_ocnt);
    chk("out_wr_idx", out_wr_idx, m_widx);
    chk("irq_status", irq_status, (m_type << 8) | (m_halt << 2) | (int'(m_err) << 1) | int'(m_done));
    chk("irq", irq, int'((m_done || m_err) && !m_mask));
  endtask

  task automatic model_step();
    bit halted = (m_halt != 0);
    bit blk = m_soe && m_err;
    int n = wr_data & 1023;
    bit w_isz = wr_en && wr_sel == 0, w_osz = wr_en && wr_sel == 1;
    bit w_add = wr_en && wr_sel == 2 && !halted, w_rem = wr_en && wr_sel == 3 && !halted;
    bit cmd = wr_en && wr_sel == 5 && wr_data[0];
    bit take_ok = take && !halted && !blk && m_icnt > 0 && !w_isz;
    bit done_ok = done && !halted && !blk && m_ocnt < m_osz && !w_osz;
    int thr = (m_thr == 0) ? 1 : m_thr;
    bit done_set = done_ok && (!m_coal || m_ocnt + 1 >= thr);
    bit e_add = 0, e_rem = 0, e_rst = 0, flush = (m_halt == 1);
    int ic = m_icnt, oc = m_ocnt, ri = m_ridx, wi = m_widx, nh = m_halt;
    bit [1:0] clr = (wr_en && wr_sel == 6) ? wr_data[1:0] : 2'b00;
    if (w_add) begin if (m_icnt + n > m_isz) e_add = 1; else ic += n; end
    if (take_ok) begin ic -= 1; ri = (m_ridx + 1 >= m_isz) ? 0 : m_ridx + 1; end
    if (w_rem) begin if (n > m_ocnt) e_rem = 1; else oc -= n; end
    if (done_ok) begin oc += 1; wi = (m_widx + 1 >= m_osz) ? 0 : m_widx + 1; end
    if (m_halt == 0 && cmd) nh = 1;
    else if (m_halt == 1) begin nh = 2; e_rst = cmd; end
    else if (m_halt == 2 && cmd) nh = 0;
    if (w_isz) m_isz = n;
    if (w_osz) m_osz = n;
    if (flush || w_isz) begin ic = 0; ri = 0; end
    if (flush || w_osz) begin oc = 0; wi = 0; end
    if (wr_en && wr_sel == 4) begin
      m_mask = wr_data[0]; m_coal = wr_data[1]; m_soe = wr_data[2]; m_thr = wr_data[15:3];
    end
    m_icnt = ic; m_ridx = ri; m_ocnt = oc; m_widx = wi; m_halt = nh;
    m_done = done_set || (m_done && !clr[0]);
    if (e_add || e_rem || e_rst) begin
      m_err = 1; m_type = e_add ? 9 : (e_rem ? 8 : 7);
    end else if (clr[1]) begin
      m_err = 0; m_type = 0;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 16'(data);
    cyc();
    wr_en = 0;
  endtask

  task automatic takes(input int k);
    for (int i = 0; i < k; i++) begin take = 1; cyc(); end
    take = 0;
  endtask

  task automatic dones(input int k);
    for (int i = 0; i < k; i++) begin done = 1; cyc(); end
    done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog got 0 exp 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; compare();            // reset state
    wr(0, 6); wr(1, 4);
    wr(2, 3); wr(0, 6);                    // size rewrite clears pending
    cur_req = "R2"; wr(2, 2); wr(2, 0); cyc();
    cur_req = "R3"; wr(2, 5);              // 2+5 > 6 refused, type 9
    cur_req = "R7"; wr(6, 2);
    cur_req = "R2"; wr(2, 4);              // exact fill, avail 0
    cur_req = "R3"; wr(2, 1);              // one past full
    cur_req = "R7"; wr(6, 3);
    cur_req = "R4"; takes(7);              // wrap and empty-take ignored
    wr(2, 3);
    take = 1; wr(2, 4); take = 0;          // 3+4 > 6 refused even with take
    take = 1; wr(2, 3); take = 0;          // 2+3 accepted alongside take
    cur_req = "R5"; dones(5);              // fill to 4, wrap, fifth ignored
    cur_req = "R6"; wr(3, 5); wr(3, 1); wr(3, 3);
    cur_req = "R7"; wr(6, 1); wr(6, 2);
    done = 1; wr(6, 1); done = 0;          // set wins over clear
    cur_req = "R1"; done = 1; wr(1, 4); done = 0;
    cur_req = "R8"; dones(1); wr(4, 1); cyc(); wr(3, 9); wr(4, 0); cyc(); wr(6, 3);
    cur_req = "R9"; wr(3, 1); wr(4, (3 << 3) | 2); dones(2); cyc(); dones(1); wr(6, 1);
    wr(3, 3); wr(4, 2); dones(1); wr(6, 1);
    cur_req = "R10"; wr(4, 4); wr(3, 5); dones(2); takes(2);
    wr(6, 2); dones(1); takes(1);
    cur_req = "R11"; wr(4, 0); wr(2, 2);
    wr(5, 1); cyc(); wr(2, 1); dones(1); takes(1); wr(5, 0); wr(5, 1); wr(2, 2);
    cur_req = "R12"; wr(6, 3); wr(5, 1); wr(5, 1); cyc(); wr(5, 1); wr(6, 2);
    cyc();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule